// File: doc/BRIEF.md
# Digital Peak Meter with Peak Hold

This block converts a stream of rectified audio magnitudes for one channel into a 21-segment LED bar graph. Each sample arrives as a 16-bit unsigned magnitude, paired with a strobe that is high in the cycle that carries that channel's sample. A stereo system uses one instance per channel and strobes each instance only in its own slot.

The magnitude is compared against a fixed ladder of 21 dBFS thresholds. The number of thresholds met is the current level. The current level is shown as a thermometer code, so a louder sample lights the bar at once and a quieter one lowers it at once. A separate hold dot marks the highest recent level. It stays lit for a set number of sample strobes, about one second at the audio rate. After that it drops to whatever level is current. Segment 0 is the lowest segment (about -60 dBFS). Segment 20 is full scale.

Top module: `peak_meter`

## Requirements
- R1: A synchronous reset clears all 21 output segments, the held peak and the hold timer. In the cycle after reset is sampled high, `seg_bar` is all zeros.
- R2: Segment i lights in the thermometer part when the magnitude is at least T[i], for bit 0 up to bit 20. The values are T = 33, 65, 130, 260, 519, 1036, 1843, 3277, 5193, 7336, 10362, 11626, 13045, 14636, 16422, 18426, 20675, 23197, 26028, 29204, 32767. These are -60, -54, -48, -42, -36, -30, -25, -20, -16, -13 dBFS, then -10 to -1 dBFS in 1 dB steps, then 0 dBFS.
- R3: Bit 20 (the top segment) lights only for a magnitude of 32767 or more. A magnitude of 32767 or more lights every segment.
- R4: A strobed sample sets the displayed level. The output reflects that level one clock after the strobe edge, whether the level rises or falls.
- R5: While `smp_valid` is low, `smp_mag` is ignored and `seg_bar` does not change.
- R6: The hold dot is bit (H-1), where H is the held level. While H is above the current level, that bit stays lit above the thermometer part.
- R7: A strobed level equal to or above the held level becomes the held level and restarts the hold timer at HOLD_SAMPLES.
- R8: Each strobe below the held level counts the timer down by one. On the HOLD_SAMPLES-th such strobe after the last restart, the held level takes that strobe's level and the timer restarts.
- R9: `seg_bar` equals the thermometer of the current level ORed with the hold dot. A held level of 0 adds no dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | High in the cycle that carries this channel's sample |
| smp_mag | input | 16 | Rectified audio magnitude, unsigned |
| seg_bar | output | 21 | Active-high LED segments, bit 0 lowest |

## Verification
The assertions assume that `smp_mag` is already a magnitude. Any value of 32767 or above is treated as full scale, and the strobe may be high in any number of consecutive cycles. The stimulus drives magnitudes across the whole 16-bit range, including 32768 and above. It mixes back-to-back strobes with long runs of idle cycles in which the magnitude changes freely. Reset is applied only on clock-aligned cycles, and the inputs are changed away from the sampling edge. A short hold length is set so that expiry and restart are reached many times.

// File: rtl/peak_meter_pkg.sv
package peak_meter_pkg;
    localparam int NUM_SEG = 21;
    localparam int LVL_W   = $clog2(NUM_SEG + 1);

    typedef logic [LVL_W-1:0] level_t;

    // Threshold of each segment, index 0 = lowest segment.
    function automatic logic [15:0] seg_threshold(input int idx);
        case (idx)
            0:       seg_threshold = 16'd33;     // -60 dBFS
            1:       seg_threshold = 16'd65;     // -54
            2:       seg_threshold = 16'd130;    // -48
            3:       seg_threshold = 16'd260;    // -42
            4:       seg_threshold = 16'd519;    // -36
            5:       seg_threshold = 16'd1036;   // -30
            6:       seg_threshold = 16'd1843;   // -25
            7:       seg_threshold = 16'd3277;   // -20
            8:       seg_threshold = 16'd5193;   // -16
            9:       seg_threshold = 16'd7336;   // -13
            10:      seg_threshold = 16'd10362;  // -10
            11:      seg_threshold = 16'd11626;
            12:      seg_threshold = 16'd13045;
            13:      seg_threshold = 16'd14636;
            14:      seg_threshold = 16'd16422;
            15:      seg_threshold = 16'd18426;
            16:      seg_threshold = 16'd20675;
            17:      seg_threshold = 16'd23197;
            18:      seg_threshold = 16'd26028;
            19:      seg_threshold = 16'd29204;  // -1
            default: seg_threshold = 16'd32767;  // 0 dBFS
        endcase
    endfunction
endpackage

// File: rtl/pm_level_quant.sv
module pm_level_quant
    import peak_meter_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] mag,
    output level_t              level
);
    logic [NUM_SEG-1:0] hit;

    // One comparator per segment.
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_cmp
        assign hit[i] = 32'(mag) >= 32'(seg_threshold(i));
    end

    always_comb begin
        level = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            level = level + level_t'(hit[i]);
        end
    end
endmodule

// File: rtl/pm_bar_encode.sv
module pm_bar_encode
    import peak_meter_pkg::*;
(
    input  level_t             cur_level,
    input  level_t             held_level,
    output logic [NUM_SEG-1:0] bar
);
    // Thermometer part plus a single hold dot.
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        assign bar[i] = (level_t'(i) < cur_level) || (held_level == level_t'(i + 1));
    end
endmodule

// File: rtl/pm_peak_hold.sv
module pm_peak_hold
    import peak_meter_pkg::*;
#(
    parameter int HOLD_SAMPLES = 48000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    input  level_t new_level,
    output level_t held_level
);
    localparam int TMR_W = $clog2(HOLD_SAMPLES + 1);
    localparam logic [TMR_W-1:0] TMR_RELOAD = TMR_W'(HOLD_SAMPLES);

    typedef struct packed {
        level_t           held;
        logic [TMR_W-1:0] timer;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            if (new_level >= st_q.held) begin
                st_d.held  = new_level;
                st_d.timer = TMR_RELOAD;
            end else if (st_q.timer <= TMR_W'(1)) begin
                st_d.held  = new_level;
                st_d.timer = TMR_RELOAD;
            end else begin
                st_d.timer = st_q.timer - TMR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_level = st_q.held;
endmodule

// File: rtl/peak_meter.sv
module peak_meter
    import peak_meter_pkg::*;
#(
    parameter int SAMPLE_W     = 16,
    parameter int HOLD_SAMPLES = 48000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_mag,
    output logic [NUM_SEG-1:0]  seg_bar
);
    typedef struct packed {
        level_t cur;
    } meter_state_t;

    meter_state_t ms_d, ms_q;
    level_t       quant_level;
    level_t       held_level;

    pm_level_quant #(.SAMPLE_W(SAMPLE_W)) u_quant (
        .mag   (smp_mag),
        .level (quant_level)
    );

    pm_peak_hold #(.HOLD_SAMPLES(HOLD_SAMPLES)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .strobe     (smp_valid),
        .new_level  (quant_level),
        .held_level (held_level)
    );

    always_comb begin
        ms_d = ms_q;
        if (smp_valid) begin
            ms_d.cur = quant_level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_q <= '0;
        end else begin
            ms_q <= ms_d;
        end
    end

    pm_bar_encode u_enc (
        .cur_level  (ms_q.cur),
        .held_level (held_level),
        .bar        (seg_bar)
    );
endmodule

// File: rtl/peak_meter_chk.sv
module peak_meter_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_mag,
    input logic [20:0]         seg_bar
);
    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> seg_bar == '0); // R1

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(seg_bar)); // R5

    AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && 32'(smp_mag) >= 32'd32767) |=> &seg_bar); // R3

    AST_ATTACK_MID: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && 32'(smp_mag) >= 32'd10362) |=> &seg_bar[10:0]); // R4

    AST_LOW_SEG: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && 32'(smp_mag) >= 32'd33) |=> seg_bar[0]); // R2
endmodule

bind peak_meter peak_meter_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_mag   (smp_mag),
    .seg_bar   (seg_bar)
);

// File: tb/peak_meter_tb.sv
`timescale 1ns/1ps
module peak_meter_tb;
    localparam int HOLD = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_mag = '0;
    logic [20:0] seg_bar;

    int checks = 0;
    int failures = 0;

    int thr [21] = '{33, 65, 130, 260, 519, 1036, 1843, 3277, 5193, 7336,
                     10362, 11626, 13045, 14636, 16422, 18426, 20675, 23197,
                     26028, 29204, 32767};

    // reference model state
    int m_cur = 0;
    int m_held = 0;
    int m_tmr = 0;

    always #2 clk = ~clk;

    peak_meter #(.SAMPLE_W(16), .HOLD_SAMPLES(HOLD)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_mag   (smp_mag),
        .seg_bar   (seg_bar)
    );

    function automatic int level_of(input int mag);
        int n = 0;
        foreach (thr[i]) if (mag >= thr[i]) n++;
        return n;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cur = 0; m_held = 0; m_tmr = 0;
        end else if (smp_valid) begin
            int lv;
            lv = level_of(int'(smp_mag));
            m_cur = lv;
            if (lv >= m_held || m_tmr <= 1) begin
                m_held = lv;
                m_tmr = HOLD;
            end else begin
                m_tmr--;
            end
        end
    end

    function automatic logic [20:0] expected_bar();
        logic [20:0] b;
        for (int i = 0; i < 21; i++) b[i] = (i < m_cur) || (m_held == i + 1);
        return b;
    endfunction

    task automatic check(input string tag);
        logic [20:0] e;
        e = expected_bar();
        checks++;
        if (seg_bar !== e) begin
            failures++;
            $display("FAIL %s: seg_bar=%b expected=%b", tag, seg_bar, e);
        end
    endtask

    // Drive at negedge, let a posedge pass, compare at the next negedge.
    task automatic step(input logic v, input int mag, input string tag);
        smp_valid = v;
        smp_mag = 16'(mag);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, $urandom_range(0, 65535), tag);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b1, 40000, "R1");
        step(1'b1, 40000, "R1");
        rst = 1'b0;
        step(1'b0, 0, "R1");
        // R2: each threshold and just below it
        for (int i = 0; i < 21; i++) begin
            step(1'b1, thr[i], "R2");
            step(1'b1, thr[i] - 1, "R2");
            rst = 1'b1; step(1'b0, 0, "R1"); rst = 1'b0;
        end
        // R3: full scale and beyond
        step(1'b1, 32766, "R3");
        step(1'b1, 32767, "R3");
        step(1'b1, 32768, "R3");
        step(1'b1, 65535, "R3");
        // R4: falls at once, rises at once
        step(1'b1, 0, "R4");
        step(1'b1, 5000, "R4");
        // R5: idle with changing input
        idle(10, "R5");
        // R6/R8: hold dot stays, then expires
        step(1'b1, 20000, "R6");
        for (int k = 0; k < HOLD + 2; k++) step(1'b1, 200, "R8");
        // R7: equal peak restarts timer
        step(1'b1, 20000, "R7");
        step(1'b1, 100, "R7");
        step(1'b1, 3, "R7");
        step(1'b1, 20000, "R7");
        for (int k = 0; k < HOLD; k++) step(1'b1, 100, "R7");
        // R9: zero level, zero held after expiry
        for (int k = 0; k < HOLD + 1; k++) step(1'b1, 0, "R9");
        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 3) == 0) step(1'b0, $urandom_range(0, 65535), "R5");
            else if ($urandom_range(0, 1) == 0) step(1'b1, $urandom_range(0, 40000), "R4");
            else step(1'b1, $urandom_range(0, 600), "R8");
        end
        rst = 1'b1; step(1'b1, 30000, "R1"); rst = 1'b0;
        step(1'b0, 0, "R1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule